// File: doc/BRIEF.md
# Character Line Repeat Scaler

This block stretches an 18-line character cell vertically to a programmable height. It takes a 7-bit height code and a double-height select. It also takes a strobe that marks the end of each output scan line. For every output scan line it presents the glyph line index (0 to 17) that the font fetch should read. When the stretched cell is complete it raises an end-of-row pulse.

The stretch does not scale every line evenly. Each of the five low code bits adds a fixed, binary-weighted group of repeated lines spread across the glyph. The two high code bits add whole-cell repeats. A line that belongs to several selected groups is repeated once for each group. Double height doubles the resulting per-line count. The block is used between the vertical timing logic, which supplies the scan-line strobe, and the font ROM address path.

Top module: `char_line_scaler`

## Requirements
- R1: After reset, `glyph_line` is 0 and `row_done` is 0.
- R2: With `height_code` = 0 and `dbl_height` = 0, each glyph line 0..17 is shown for exactly one scan line, giving a cell height of 18.
- R3: `height_code` bit 0 adds one extra scan line to glyph line 8 only.
- R4: `height_code` bit 1 adds one extra scan line to each of glyph lines 4 and 12.
- R5: `height_code` bit 2 adds one extra scan line to each of glyph lines 2, 6, 10 and 14.
- R6: `height_code` bit 3 adds one extra scan line to each odd glyph line from 1 to 15.
- R7: `height_code` bit 4 adds one extra scan line to each glyph line from 1 to 16.
- R8: `height_code` bits [6:5], read as a value k of 0 to 3, add k extra scan lines to every glyph line.
- R9: The extras of all selected bits add up per line. The cell height is 18*(1+k) plus `height_code` bits [4:0] read as an unsigned number.
- R10: With `dbl_height` = 1, every per-line count, and so the cell height, is doubled.
- R11: While `line_strobe` is low, `glyph_line` does not change.
- R12: `row_done` is high, combinationally, exactly during the `line_strobe` cycle that ends the last scan line of glyph line 17. On the next cycle `glyph_line` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| height_code | input | 7 | Height code: [4:0] weighted repeat groups, [6:5] whole-cell repeats |
| dbl_height | input | 1 | Doubles every per-line repeat count |
| line_strobe | input | 1 | One-cycle pulse ending the current output scan line |
| glyph_line | output | 5 | Glyph line index for the current scan line |
| row_done | output | 1 | High on the strobe that completes the stretched cell |

## Verification
The hardest case to reach is the scan line with the largest count. That is an odd line or line 8 with bits 4, 3 or 0 set and k = 3 under double height, which gives 12 scan lines. The repeat counter only gets there after a long, unbroken run of strobes with that code. The bench gets there with a directed all-ones code, with and without double height. It also replays random codes over whole cells, with random idle gaps between strobes. Each line's dwell and the total height are compared with the requirement formulas.

// File: rtl/line_scaler_pkg.sv
package line_scaler_pkg;
  localparam int GLYPH_LINES = 18;
  localparam int LINE_W      = 5;
  localparam int CODE_W      = 7;
  localparam int CNT_W       = 4;

  // Number of weighted groups (code bits [4:0]) that contain line n.
  function automatic logic [2:0] weight_hits(input logic [4:0] w, input logic [LINE_W-1:0] n);
    logic [2:0] s;
    s = '0;
    if (w[0] && n == 5'd8)                       s = s + 3'd1;
    if (w[1] && n[2:0] == 3'd4)                  s = s + 3'd1;
    if (w[2] && n[1:0] == 2'd2 && n < 5'd16)     s = s + 3'd1;
    if (w[3] && n[0] && n < 5'd16)               s = s + 3'd1;
    if (w[4] && n >= 5'd1 && n <= 5'd16)         s = s + 3'd1;
    return s;
  endfunction

  // Scan lines spent on glyph line n.
  function automatic logic [CNT_W-1:0] line_count(input logic [CODE_W-1:0] code,
                                                  input logic dbl,
                                                  input logic [LINE_W-1:0] n);
    logic [CNT_W-1:0] c;
    c = CNT_W'(1) + CNT_W'(code[6:5]) + CNT_W'(weight_hits(code[4:0], n));
    return dbl ? CNT_W'(c << 1) : c;
  endfunction
endpackage

// File: rtl/line_weight.sv
module line_weight
  import line_scaler_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              dbl,
  input  logic [LINE_W-1:0] line,
  output logic [CNT_W-1:0]  count
);
  always_comb count = line_count(code, dbl, line);
endmodule

// File: rtl/cell_sequencer.sv
module cell_sequencer
  import line_scaler_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [CNT_W-1:0]  count,
  output logic [LINE_W-1:0] line,
  output logic              last_scan,
  output logic              cell_end
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(GLYPH_LINES - 1);

  logic [CNT_W-1:0] rep_q;

  // >= keeps the sequencer safe if the code shrinks mid-line
  assign last_scan = (CNT_W'(rep_q + 1'b1) >= count);
  assign cell_end  = step && last_scan && (line == LAST_LINE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line  <= '0;
      rep_q <= '0;
    end else if (step) begin
      if (last_scan) begin
        rep_q <= '0;
        line  <= (line == LAST_LINE) ? '0 : line + 1'b1;
      end else begin
        rep_q <= rep_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/char_line_scaler.sv
module char_line_scaler
  import line_scaler_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  height_code,
  input  logic        dbl_height,
  input  logic        line_strobe,
  output logic [4:0]  glyph_line,
  output logic        row_done
);
  logic [CNT_W-1:0]  cur_count;
  logic [LINE_W-1:0] cur_line;
  logic              last_scan;
  logic              cell_end;

  line_weight u_weight (
    .code  (height_code),
    .dbl   (dbl_height),
    .line  (cur_line),
    .count (cur_count)
  );

  cell_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (line_strobe),
    .count     (cur_count),
    .line      (cur_line),
    .last_scan (last_scan),
    .cell_end  (cell_end)
  );

  assign glyph_line = cur_line;
  assign row_done   = cell_end;
endmodule

// File: rtl/char_line_scaler_chk.sv
module char_line_scaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_strobe,
  input logic [4:0] glyph_line,
  input logic       row_done,
  input logic       last_scan
);
  assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    glyph_line <= 5'd17);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !line_strobe |=> $stable(glyph_line));

  assert_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> glyph_line == 5'd0);

  assert_done_pos_R12: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> (line_strobe && glyph_line == 5'd17 && last_scan));

  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && glyph_line != 5'd17) |=>
      (glyph_line == $past(glyph_line) || glyph_line == $past(glyph_line) + 5'd1));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (glyph_line == 5'd0));
endmodule

bind char_line_scaler char_line_scaler_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_strobe (line_strobe),
  .glyph_line  (glyph_line),
  .row_done    (row_done),
  .last_scan   (last_scan)
);

// File: tb/test_char_line_scaler.sv
`timescale 1ns/1ps
module test_char_line_scaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] height_code = '0;
  logic       dbl_height = 1'b0;
  logic       line_strobe = 1'b0;
  logic [4:0] glyph_line;
  logic       row_done;

  int total = 0;
  int bad = 0;
  int seed = 32'h5eed1;

  always #5 clk = ~clk;

  char_line_scaler i_char_line_scaler (
    .clk(clk), .rst_n(rst_n), .height_code(height_code), .dbl_height(dbl_height),
    .line_strobe(line_strobe), .glyph_line(glyph_line), .row_done(row_done)
  );

  // Group membership as 18-bit masks, bit n = glyph line n.
  function automatic int exp_count(input logic [6:0] code, input logic dbl, input int n);
    logic [17:0] masks [5];
    int c;
    masks[0] = 18'h00100;                       // line 8
    masks[1] = 18'h01010;                       // 4, 12
    masks[2] = 18'h04444;                       // 2, 6, 10, 14
    masks[3] = 18'h0AAAA;                       // odd 1..15
    masks[4] = 18'h1FFFE;                       // 1..16
    c = 1 + int'(code[6:5]);
    for (int b = 0; b < 5; b++) if (code[b] && masks[b][n]) c++;
    return dbl ? 2 * c : c;
  endfunction

  function automatic int exp_height(input logic [6:0] code, input logic dbl);
    int h;
    h = 18 * (1 + int'(code[6:5])) + int'(code[4:0]);
    return dbl ? 2 * h : h;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one complete cell; sequencer must be at line 0, repeat 0.
  task automatic run_cell(input logic [6:0] code, input logic dbl, input string req, input bit gaps);
    int seen = 0;
    int mism = 0;
    int done_err = 0;
    @(negedge clk);
    height_code = code;
    dbl_height  = dbl;
    for (int n = 0; n < 18; n++) begin
      int c;
      c = exp_count(code, dbl, n);
      for (int r = 0; r < c; r++) begin
        if (gaps && ($urandom(seed) % 4 == 0)) begin
          seed = seed + 1;
          @(negedge clk);
          @(negedge clk);
          // R11: idle cycles leave the line unchanged
          if (glyph_line != 5'(n)) begin
            check(1'b0, "R11", glyph_line, n);
          end
        end
        if (glyph_line != 5'(n) && mism == 0) begin
          mism++;
          check(1'b0, req, glyph_line, n);
        end
        line_strobe = 1'b1;
        #1;
        if (row_done != ((n == 17) && (r == c - 1))) begin
          done_err++;
          check(1'b0, "R12", row_done, (n == 17) && (r == c - 1));
        end
        seen++;
        @(negedge clk);
        line_strobe = 1'b0;
      end
    end
    check(mism == 0, req, mism, 0);
    check(seen == exp_height(code, dbl), "R9", seen, exp_height(code, dbl));
    check(done_err == 0 && glyph_line == 5'd0, "R12", glyph_line, 0);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(glyph_line == 5'd0, "R1", glyph_line, 0);
    check(row_done == 1'b0, "R1", row_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(glyph_line == 5'd0, "R1", glyph_line, 0);

    run_cell(7'h00, 1'b0, "R2", 1'b0);
    run_cell(7'h01, 1'b0, "R3", 1'b0);
    run_cell(7'h02, 1'b0, "R4", 1'b0);
    run_cell(7'h04, 1'b0, "R5", 1'b0);
    run_cell(7'h08, 1'b0, "R6", 1'b0);
    run_cell(7'h10, 1'b0, "R7", 1'b0);
    run_cell(7'h20, 1'b0, "R8", 1'b0);
    run_cell(7'h40, 1'b0, "R8", 1'b0);
    run_cell(7'h60, 1'b0, "R8", 1'b0);
    run_cell(7'h1F, 1'b0, "R9", 1'b0);
    run_cell(7'h7F, 1'b0, "R9", 1'b1);
    run_cell(7'h00, 1'b1, "R10", 1'b0);
    run_cell(7'h7F, 1'b1, "R10", 1'b1);
    run_cell(7'h15, 1'b1, "R10", 1'b0);
    for (int i = 0; i < 24; i++) begin
      logic [6:0] rc;
      logic rd;
      rc = 7'($urandom(seed));
      rd = 1'($urandom(seed + 7));
      seed = seed + 13;
      run_cell(rc, rd, "R9", 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule